// File: doc/BRIEF.md
# Data Address Watchpoint Qualifier

This block compares every data access against a single watched address. It then decides whether the access should raise a data storage interrupt. The watched address is compared at doubleword granularity. A match counts only when the privilege state of the access has its own enable set in the watch control word. The translation rule must also agree with the data-relocate state, and the access type (load or store) must be enabled.

When a match qualifies, the next cycle shows three things. The interrupt request is high for that cycle. The fault address output holds the full address of the access. The status output holds the single watchpoint reason bit. A match that fails to qualify leaves nothing behind: no request, and both captured registers keep their previous values. The surrounding core samples the request and the two captured values in that cycle to take the interrupt.

Top module: `dwq_top`

## Requirements
- R1: Addresses are compared with the low three bits ignored. A difference in any higher bit of `acc_addr` against `wp_addr` means no request.
- R2: An access made with `st_pr`=1 (problem state) qualifies only when the problem enable `wp_ctl[0]` is 1.
- R3: An access made with `st_pr`=0 and `st_hv`=1 (hypervisor state) qualifies only when the hypervisor enable `wp_ctl[2]` is 1.
- R4: An access made with `st_pr`=0 and `st_hv`=0 (supervisor state) qualifies only when the supervisor enable `wp_ctl[1]` is 1.
- R5: When the translation-ignore bit `wp_ctl[3]` is 0, an access qualifies only if the translated-mode bit `wp_ctl[4]` equals `st_dr`. So `wp_ctl[4]`=1 catches translated accesses only, and 0 catches real-mode accesses only.
- R6: When `wp_ctl[3]` is 1, `st_dr` and `wp_ctl[4]` have no effect on qualification.
- R7: A load (`acc_store`=0) qualifies only if the read enable `wp_ctl[5]` is 1. A store qualifies only if the write enable `wp_ctl[6]` is 1.
- R8: One cycle after a qualifying access, three outputs are set. `dsi_req` is 1. `dar_q` equals the full access address, low bits included. `dsisr_q` has only bit 22 set, which is the watchpoint reason bit at position 41 of a 64-bit big-endian-numbered status word.
- R9: A hit does not persist. In a cycle that follows no access, or an access that did not qualify, `dsi_req` is 0 and `dar_q` and `dsisr_q` keep their values.
- R10: While `rst_n` is low, `dsi_req`, `dar_q` and `dsisr_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W | Effective address of the access |
| wp_addr | input | ADDR_W | Watched address |
| wp_ctl | input | 7 | Watch control: [0] problem en, [1] supervisor en, [2] hypervisor en, [3] translation ignore, [4] translated mode, [5] read en, [6] write en |
| st_pr | input | 1 | Machine state: problem state |
| st_hv | input | 1 | Machine state: hypervisor |
| st_dr | input | 1 | Machine state: data relocation on |
| dsi_req | output | 1 | Data storage interrupt request, one cycle per qualifying access |
| dar_q | output | ADDR_W | Captured fault address |
| dsisr_q | output | STATUS_W | Captured status with the watchpoint reason bit |

## Verification
A new qualifying access can arrive in the same cycle that the request for the previous hit is on the output. The capture of a fresh address then overlaps the presentation of the old one. The bench provokes this with directed back-to-back hits that carry different low address bits, and with a hit followed at once by a non-qualifying match. It judges each cycle on its own terms: the request must stay high for exactly as long as qualifying accesses continue, `dar_q` must track the newest qualifying address, and a following non-qualifying access must drop the request while the last captured address stays in place.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
   localparam int CTL_W      = 7;
   localparam int CTL_PR_EN  = 0;
   localparam int CTL_SV_EN  = 1;
   localparam int CTL_HV_EN  = 2;
   localparam int CTL_XIGN   = 3;
   localparam int CTL_XMODE  = 4;
   localparam int CTL_RD_EN  = 5;
   localparam int CTL_WR_EN  = 6;

   typedef enum logic [1:0] {
      PRIV_SUP  = 2'd0,
      PRIV_HYP  = 2'd1,
      PRIV_PROB = 2'd2
   } priv_e;

   function automatic priv_e priv_of(input logic pr, input logic hv);
      if (pr)      return PRIV_PROB;
      else if (hv) return PRIV_HYP;
      else         return PRIV_SUP;
   endfunction
endpackage

// File: rtl/dwq_addr_cmp.sv
module dwq_addr_cmp #(
   parameter int ADDR_W   = 64,
   parameter int GRAN_LSB = 3
) (
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              match
);
   localparam int HI = ADDR_W - 1;

   generate
      if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad
         $error("dwq_addr_cmp: GRAN_LSB out of range");
      end
      if (GRAN_LSB == 0) begin : g_exact
         assign match = (a_addr == b_addr);
      end else begin : g_gran
         assign match = (a_addr[HI:GRAN_LSB] == b_addr[HI:GRAN_LSB]);
      end
   endgenerate
endmodule

// File: rtl/dwq_qual.sv
module dwq_qual
   import dwq_pkg::*;
(
   input  logic [CTL_W-1:0] ctl,
   input  logic             pr,
   input  logic             hv,
   input  logic             dr,
   input  logic             is_store,
   output logic             ok
);
   logic priv_ok;
   logic xlate_ok;
   logic type_ok;
   priv_e lvl;

   always_comb begin
      lvl = priv_of(pr, hv);
      unique case (lvl)
         PRIV_PROB: priv_ok = ctl[CTL_PR_EN];
         PRIV_HYP:  priv_ok = ctl[CTL_HV_EN];
         default:   priv_ok = ctl[CTL_SV_EN];
      endcase
   end

   always_comb begin
      if (ctl[CTL_XIGN]) xlate_ok = 1'b1;
      else               xlate_ok = (ctl[CTL_XMODE] == dr);
   end

   assign type_ok = is_store ? ctl[CTL_WR_EN] : ctl[CTL_RD_EN];
   assign ok      = priv_ok & xlate_ok & type_ok;
endmodule

// File: rtl/dwq_top.sv
module dwq_top
   import dwq_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int GRAN_LSB   = 3,
   parameter int STATUS_W   = 32,
   parameter int REASON_BIT = 22
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_store,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic [ADDR_W-1:0]   wp_addr,
   input  logic [CTL_W-1:0]    wp_ctl,
   input  logic                st_pr,
   input  logic                st_hv,
   input  logic                st_dr,
   output logic                dsi_req,
   output logic [ADDR_W-1:0]   dar_q,
   output logic [STATUS_W-1:0] dsisr_q
);
   localparam logic [STATUS_W-1:0] REASON_VAL = STATUS_W'(1) << REASON_BIT;

   generate
      if (REASON_BIT < 0 || REASON_BIT >= STATUS_W) begin : g_bad_reason
         $error("dwq_top: REASON_BIT outside status word");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("dwq_top: ADDR_W too small");
      end
   endgenerate

   logic addr_hit;
   logic qual_ok;
   logic take;

   dwq_addr_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) i_cmp (
      .a_addr (acc_addr),
      .b_addr (wp_addr),
      .match  (addr_hit)
   );

   dwq_qual i_qual (
      .ctl      (wp_ctl),
      .pr       (st_pr),
      .hv       (st_hv),
      .dr       (st_dr),
      .is_store (acc_store),
      .ok       (qual_ok)
   );

   assign take = acc_valid & addr_hit & qual_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dsi_req <= 1'b0;
         dar_q   <= '0;
         dsisr_q <= '0;
      end else begin
         dsi_req <= take;
         if (take) begin
            dar_q   <= acc_addr;
            dsisr_q <= REASON_VAL;
         end
      end
   end

   AST_REQ_DAR: assert property (@(posedge clk) disable iff (!rst_n)
      dsi_req |-> dar_q == $past(acc_addr)) else $error("dar mismatch"); // R8
   AST_REQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      dsi_req |-> $onehot0(dsisr_q) && dsisr_q[REASON_BIT]) else $error("status"); // R8
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !dsi_req) else $error("idle req"); // R9
   AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !dsi_req |-> $stable(dar_q) && $stable(dsisr_q)) else $error("hold"); // R9
   AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr[ADDR_W-1:GRAN_LSB] != wp_addr[ADDR_W-1:GRAN_LSB]) |=> !dsi_req)
      else $error("addr miss"); // R1
   AST_PROB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_pr && !wp_ctl[CTL_PR_EN]) |=> !dsi_req) else $error("prob"); // R2
   AST_HYP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_pr && st_hv && !wp_ctl[CTL_HV_EN]) |=> !dsi_req) else $error("hyp"); // R3
   AST_SUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_pr && !st_hv && !wp_ctl[CTL_SV_EN]) |=> !dsi_req) else $error("sup"); // R4
   AST_XLATE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_ctl[CTL_XIGN] && (wp_ctl[CTL_XMODE] != st_dr)) |=> !dsi_req)
      else $error("xlate"); // R5
   AST_TYPE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_store && !wp_ctl[CTL_WR_EN]) || (!acc_store && !wp_ctl[CTL_RD_EN])) |=> !dsi_req)
      else $error("type"); // R7
endmodule

// File: tb/test_dwq_top.sv
module test_dwq_top;
   localparam int PERIOD = 10;
   localparam int AW = 64;
   localparam int SW = 32;
   localparam logic [SW-1:0] REASON = 32'h0040_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic          acc_store = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [AW-1:0] wp_addr = '0;
   logic [6:0]    wp_ctl = '0;
   logic          st_pr = 1'b0;
   logic          st_hv = 1'b0;
   logic          st_dr = 1'b0;
   logic          dsi_req;
   logic [AW-1:0] dar_q;
   logic [SW-1:0] dsisr_q;

   int errors = 0;
   int checks = 0;
   logic [AW-1:0] m_dar = '0;
   logic [SW-1:0] m_sr = '0;

   always #(PERIOD/2) clk = ~clk;

   dwq_top i_dwq_top (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
      .acc_addr(acc_addr), .wp_addr(wp_addr), .wp_ctl(wp_ctl),
      .st_pr(st_pr), .st_hv(st_hv), .st_dr(st_dr),
      .dsi_req(dsi_req), .dar_q(dar_q), .dsisr_q(dsisr_q)
   );

   function automatic logic model_hit(input logic v, input logic st,
                                      input logic [AW-1:0] a, input logic [AW-1:0] w,
                                      input logic [6:0] c, input logic pr,
                                      input logic hv, input logic dr);
      logic p, x, t;
      if (pr)      p = c[0];
      else if (hv) p = c[2];
      else         p = c[1];
      x = c[3] ? 1'b1 : (c[4] == dr);
      t = st ? c[6] : c[5];
      return v && (a[AW-1:3] == w[AW-1:3]) && p && x && t;
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic v, input logic st,
                       input logic [AW-1:0] a, input logic [6:0] c,
                       input logic pr, input logic hv, input logic dr);
      logic h;
      acc_valid = v; acc_store = st; acc_addr = a; wp_ctl = c;
      st_pr = pr; st_hv = hv; st_dr = dr;
      h = model_hit(v, st, a, wp_addr, c, pr, hv, dr);
      if (h) begin m_dar = a; m_sr = REASON; end
      @(posedge clk);
      #1;
      check({tag, " req"}, {63'd0, dsi_req}, {63'd0, h});
      check({tag, " dar"}, dar_q, m_dar);
      check({tag, " dsisr"}, {32'd0, dsisr_q}, {32'd0, m_sr});
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2718);
      wp_addr = 64'h0000_1234_5678_9A40;
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset req", {63'd0, dsi_req}, 64'd0);
      check("R10 reset dar", dar_q, 64'd0);
      check("R10 reset dsisr", {32'd0, dsisr_q}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // supervisor, translation ignored, loads enabled: hit with low bits R8
      step("R8 hit", 1, 0, wp_addr | 64'h5, 7'b0101010, 0, 0, 0);
      step("R1 low bits ignored", 1, 0, wp_addr | 64'h7, 7'b0101010, 0, 0, 1);
      step("R1 bit3 differs", 1, 0, wp_addr ^ 64'h8, 7'b0101010, 0, 0, 0);
      step("R1 top bit differs", 1, 0, wp_addr ^ 64'h8000_0000_0000_0000, 7'b0101010, 0, 0, 0);
      step("R2 prob disabled", 1, 0, wp_addr, 7'b0101110, 1, 0, 0);
      step("R2 prob enabled", 1, 0, wp_addr, 7'b0101001, 1, 1, 0);
      step("R3 hyp disabled", 1, 0, wp_addr, 7'b0101011, 0, 1, 0);
      step("R3 hyp enabled", 1, 0, wp_addr, 7'b0101100, 0, 1, 0);
      step("R4 sup disabled", 1, 0, wp_addr, 7'b0101101, 0, 0, 0);
      step("R5 wt1 real miss", 1, 0, wp_addr, 7'b0110010, 0, 0, 0);
      step("R5 wt1 xlate hit", 1, 0, wp_addr | 64'h1, 7'b0110010, 0, 0, 1);
      step("R5 wt0 xlate miss", 1, 0, wp_addr, 7'b0100010, 0, 0, 1);
      step("R5 wt0 real hit", 1, 0, wp_addr | 64'h2, 7'b0100010, 0, 0, 0);
      step("R6 ignore dr1", 1, 0, wp_addr | 64'h3, 7'b0101010, 0, 0, 1);
      step("R6 ignore dr0 wt1", 1, 0, wp_addr | 64'h4, 7'b0111010, 0, 0, 0);
      step("R7 store no wr", 1, 1, wp_addr, 7'b0101010, 0, 0, 0);
      step("R7 store wr", 1, 1, wp_addr | 64'h6, 7'b1001010, 0, 0, 0);
      step("R7 load no rd", 1, 0, wp_addr, 7'b1001010, 0, 0, 0);
      // back-to-back hits then non-qualifying match R9
      step("R8 b2b first", 1, 0, wp_addr | 64'h1, 7'b1111110, 0, 0, 0);
      step("R8 b2b second", 1, 1, wp_addr | 64'h2, 7'b1111110, 0, 0, 0);
      step("R9 unqualified after hit", 1, 1, wp_addr | 64'h3, 7'b0111110, 0, 0, 0);
      step("R9 idle", 0, 0, wp_addr, 7'b1111111, 0, 0, 0);
      step("R9 valid low match", 0, 1, wp_addr, 7'b1111111, 1, 1, 1);

      for (int i = 0; i < 600; i++) begin
         logic [AW-1:0] a;
         a = {$urandom, $urandom};
         if ($urandom % 2) a = {wp_addr[AW-1:3], a[2:0]};
         step("R1-R9 random", ($urandom % 4) != 0, $urandom % 2, a,
              7'($urandom), $urandom % 2, $urandom % 2, $urandom % 2);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule